// File: doc/BRIEF.md
# Instruction trace view filter

This block sits beside a processor's retire stage and decides, for every retired instruction beat, whether that instruction belongs in the trace. Each beat presents the instruction address, the exception level it ran at and whether it ran in the non-secure state. The filter combines three conditions:

- an enabling event;
- an include test against up to eight programmable address ranges;
- a start/stop state machine driven by single-address comparators.

The result is a registered per-beat trace-enable flag.

Software programs the filter through a simple register write port while the unit is stopped. It then sets the run bit. Once the unit is running, configuration writes have no effect, with one exception: writes to the run control register. The start/stop state can be loaded before a run, so that a stopped session resumes where it left off. It stays visible on a port after the unit is stopped, so software can save it. Out of reset the filter is set up to trace every address once it is enabled.

Top module: `itrace_view_filter`

## Requirements
- R1: Reset state:
  - `idle` is 1, `trace_en` is 0 and `ss_started` is 1.
  - The configuration is event select 1, include mask bit 0 set, start/stop selection 0, comparator 0 = 0 and comparator 1 = all ones.
  - As a result, after enabling, every beat is traced.
- R2: Run control:
  - Bit 0 of register 0x00 runs the unit.
  - `idle` falls to 0 one cycle after the cycle in which run becomes 1.
  - `idle` rises to 1 one cycle after run returns to 0.
- R3: Output timing:
  - `trace_en` is registered. It is high in the cycle after an accepted beat that passes all conditions.
  - It is low after a cycle with no beat, and low for every beat taken while the unit is not running.
- R4: Enabling event:
  - The event select field is bits 7:0 of register 0x01.
  - The value 1 is always true. Any other value, including 0, never enables tracing.
- R5: Range include:
  - Pair k uses comparator 2k as the low bound and comparator 2k+1 as the high bound. Comparator i's value is at register 0x10+i.
  - Bit k of the include register 0x02 selects pair k.
  - A beat is included when low ≤ address ≤ high, with both bounds inclusive, for any selected pair.
- R6: When the include register is 0, every address is included.
- R7: Access-type masking:
  - Comparator i's access type is at register 0x20+i.
  - Bits 11:8 mask secure exception levels 0 to 3. Bits 15:12 mask non-secure levels 0 to 3.
  - A set bit means the comparator never matches at that level.
  - A range matches only if both of its comparators allow the level.
- R8: Start/stop:
  - Register 0x03 bit i makes comparator i a start point, and bit 16+i makes it a stop point. Each point matches an exact address.
  - With no bit set, the start/stop condition is always true.
  - Otherwise a start hit sets the state and a stop hit clears it. The new state applies from the next beat.
- R9: When a start hit and a stop hit occur on the same beat, the stop wins and the state is cleared.
- R10: Start/stop state preset and hold:
  - Bit 9 of register 0x01 written while stopped presets the state.
  - The state is shown on `ss_started` and is held unchanged while the unit is stopped.
- R11: While the unit is running, writes to any register other than 0x00 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register index |
| wr_data | input | 64 | Register write data |
| ins_valid | input | 1 | Retired instruction beat present |
| ins_addr | input | 64 | Instruction address |
| ins_el | input | 2 | Exception level of the instruction |
| ins_ns | input | 1 | 1 when the instruction ran in the non-secure state |
| trace_en | output | 1 | Registered trace decision for the previous beat |
| idle | output | 1 | 1 while the unit is stopped |
| ss_started | output | 1 | Current start/stop state |

## Verification
Every beat decision is due on `trace_en` exactly one clock after the edge that accepted the beat. The driver queues the expected value when it presents a beat, and the monitor captures `ins_valid` at that edge. The monitor then compares at the following falling edge. The idle flag is due two edges after a run write: it is checked once at the falling edge right after the write, where it must still show the old value, and again one cycle later. Start/stop effects are checked on the beat that follows the hit, never on the hit itself.

// File: rtl/itrace_view_filter.sv
module itrace_view_filter #(
  parameter int ADDR_W    = 64,
  parameter int NUM_PAIRS = 8,
  parameter int REG_AW    = 8,
  parameter int DATA_W    = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ins_valid,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [1:0]        ins_el,
  input  logic              ins_ns,
  output logic              trace_en,
  output logic              idle,
  output logic              ss_started
);
  localparam int NUM_CMP  = 2 * NUM_PAIRS;
  localparam int STOP_LSB = 16;
  localparam int VAL_BASE = 16;
  localparam int ACC_BASE = 32;
  localparam logic [REG_AW-1:0] A_RUN  = REG_AW'(0);
  localparam logic [REG_AW-1:0] A_VIEW = REG_AW'(1);
  localparam logic [REG_AW-1:0] A_INCL = REG_AW'(2);
  localparam logic [REG_AW-1:0] A_SSEL = REG_AW'(3);

  logic                 en_q, run_q, ss_q, trace_q;
  logic [7:0]           evsel_q;
  logic [NUM_PAIRS-1:0] incl_q, in_rng;
  logic [NUM_CMP-1:0]   start_q, stop_q, allowed, hit_eq;
  logic [ADDR_W-1:0]    cmp_val [NUM_CMP];
  logic [7:0]           cmp_acc [NUM_CMP];

  wire cfg_wr = wr_en && !en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      run_q   <= 1'b0;
      evsel_q <= 8'd1;
      incl_q  <= NUM_PAIRS'(1);
      start_q <= '0;
      stop_q  <= '0;
    end else begin
      run_q <= en_q;
      if (wr_en && wr_addr == A_RUN) en_q <= wr_data[0];
      if (cfg_wr && wr_addr == A_VIEW) evsel_q <= wr_data[7:0];
      if (cfg_wr && wr_addr == A_INCL) incl_q <= wr_data[NUM_PAIRS-1:0];
      if (cfg_wr && wr_addr == A_SSEL) begin
        start_q <= wr_data[NUM_CMP-1:0];
        stop_q  <= wr_data[STOP_LSB +: NUM_CMP];
      end
    end
  end

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_val[i] <= (i == 1) ? '1 : '0;
        cmp_acc[i] <= '0;
      end else begin
        if (cfg_wr && wr_addr == REG_AW'(VAL_BASE + i)) cmp_val[i] <= wr_data[ADDR_W-1:0];
        if (cfg_wr && wr_addr == REG_AW'(ACC_BASE + i)) cmp_acc[i] <= wr_data[15:8];
      end
    end
    assign allowed[i] = !cmp_acc[i][{ins_ns, ins_el}];
    assign hit_eq[i]  = allowed[i] && (ins_addr == cmp_val[i]);
  end

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
    assign in_rng[k] = allowed[2*k] && allowed[2*k+1] &&
                       (ins_addr >= cmp_val[2*k]) && (ins_addr <= cmp_val[2*k+1]);
  end

  wire start_hit = |(hit_eq & start_q);
  wire stop_hit  = |(hit_eq & stop_q);
  wire ss_used   = |{start_q, stop_q};
  wire incl_ok   = (incl_q == '0) || |(in_rng & incl_q);
  wire ss_ok     = !ss_used || ss_q;
  wire event_ok  = (evsel_q == 8'd1);
  wire beat      = en_q && ins_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_q    <= 1'b1;
      trace_q <= 1'b0;
    end else begin
      trace_q <= beat && event_ok && incl_ok && ss_ok;
      if (cfg_wr && wr_addr == A_VIEW) ss_q <= wr_data[9];
      else if (beat && ss_used) begin
        if (stop_hit)       ss_q <= 1'b0;
        else if (start_hit) ss_q <= 1'b1;
      end
    end
  end

  assign trace_en   = trace_q;
  assign idle       = !run_q;
  assign ss_started = ss_q;

  AST_IDLE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> idle); // R2
  AST_TRACE_NEEDS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    trace_en |-> $past(en_q && ins_valid)); // R3
  AST_START_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    beat && start_hit && !stop_hit |=> ss_started); // R8
  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    beat && stop_hit |=> !ss_started); // R9
  AST_SS_HELD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q && !(wr_en && wr_addr == A_VIEW) |=> $stable(ss_started)); // R10
  AST_CFG_FROZEN_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> $stable(incl_q) && $stable(evsel_q) && $stable(start_q) && $stable(stop_q)); // R11
endmodule

// File: tb/tb_itrace_view_filter.sv
module tb_itrace_view_filter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, ins_valid = 1'b0, ins_ns = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [63:0] wr_data = '0, ins_addr = '0;
  logic [1:0]  ins_el = '0;
  logic        trace_en, idle, ss_started;

  int checks = 0, errors = 0;
  bit    exp_q[$];
  string tag_q[$];

  itrace_view_filter dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ins_valid(ins_valid), .ins_addr(ins_addr), .ins_el(ins_el), .ins_ns(ins_ns),
    .trace_en(trace_en), .idle(idle), .ss_started(ss_started));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic beat(logic [63:0] a, logic [1:0] el, logic ns, bit exp, string tag);
    @(negedge clk);
    ins_valid = 1'b1; ins_addr = a; ins_el = el; ins_ns = ns;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    ins_valid = 1'b0;
  endtask

  initial begin : monitor
    forever begin
      bit v;
      @(posedge clk);
      v = ins_valid;
      @(negedge clk);
      if (v && exp_q.size() > 0) chk(tag_q.pop_front(), 64'(trace_en), 64'(exp_q.pop_front()));
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle at reset", 64'(idle), 64'd1);
    chk("R1 trace_en at reset", 64'(trace_en), 64'd0);
    chk("R1 ss_started at reset", 64'(ss_started), 64'd1);

    wr(8'h00, 64'd1);
    chk("R2 idle same cycle as run", 64'(idle), 64'd1);
    @(negedge clk);
    chk("R2 idle after run", 64'(idle), 64'd0);
    beat(64'h1234, 2'd0, 1'b1, 1'b1, "R1 default traces low address");
    beat(64'hFFFF_FFFF_FFFF_FFFF, 2'd2, 1'b0, 1'b1, "R1 default traces top address");

    wr(8'h02, 64'h2);
    beat(64'h5, 2'd0, 1'b1, 1'b1, "R11 include write ignored while running");
    wr(8'h01, 64'h200);
    beat(64'h6, 2'd0, 1'b1, 1'b1, "R11 view write ignored while running");

    wr(8'h00, 64'd0);
    @(negedge clk);
    chk("R2 idle after stop", 64'(idle), 64'd1);
    beat(64'h7, 2'd0, 1'b1, 1'b0, "R3 beat while stopped");
    @(negedge clk);
    chk("R3 no beat gives low", 64'(trace_en), 64'd0);

    wr(8'h12, 64'h1000); wr(8'h13, 64'h1FFF); wr(8'h02, 64'h2);
    wr(8'h00, 64'd1);
    beat(64'h0FFF, 2'd0, 1'b1, 1'b0, "R5 below low bound");
    beat(64'h1000, 2'd0, 1'b1, 1'b1, "R5 at low bound");
    beat(64'h1FFF, 2'd0, 1'b1, 1'b1, "R5 at high bound");
    beat(64'h2000, 2'd0, 1'b1, 1'b0, "R5 above high bound");

    wr(8'h00, 64'd0);
    wr(8'h22, 64'h2000); wr(8'h23, 64'h0100);
    wr(8'h00, 64'd1);
    beat(64'h1800, 2'd1, 1'b1, 1'b0, "R7 nonsecure EL1 masked on low cmp");
    beat(64'h1800, 2'd0, 1'b1, 1'b1, "R7 nonsecure EL0 allowed");
    beat(64'h1800, 2'd1, 1'b0, 1'b1, "R7 secure EL1 allowed");
    beat(64'h1800, 2'd0, 1'b0, 1'b0, "R7 secure EL0 masked on high cmp");

    wr(8'h00, 64'd0);
    wr(8'h22, 64'h0); wr(8'h23, 64'h0); wr(8'h02, 64'h0);
    wr(8'h00, 64'd1);
    beat(64'h0, 2'd0, 1'b1, 1'b1, "R6 empty include, address 0");
    beat(64'hDEAD_0000_0000_0000, 2'd3, 1'b0, 1'b1, "R6 empty include, high address");

    wr(8'h00, 64'd0);
    wr(8'h01, 64'h202);
    wr(8'h00, 64'd1);
    beat(64'h40, 2'd0, 1'b1, 1'b0, "R4 event select 2 never enables");
    wr(8'h00, 64'd0);
    wr(8'h01, 64'h000);
    wr(8'h00, 64'd1);
    beat(64'h40, 2'd0, 1'b1, 1'b0, "R4 event select 0 never enables");

    wr(8'h00, 64'd0);
    wr(8'h14, 64'h4000); wr(8'h15, 64'h5000);
    wr(8'h03, (64'd1 << 4) | (64'd1 << 21));
    wr(8'h01, 64'h001);
    chk("R10 preset stopped", 64'(ss_started), 64'd0);
    wr(8'h00, 64'd1);
    beat(64'h100,  2'd0, 1'b1, 1'b0, "R8 stopped state blocks");
    beat(64'h4000, 2'd0, 1'b1, 1'b0, "R8 start hit applies next beat");
    beat(64'h4004, 2'd0, 1'b1, 1'b1, "R8 traced after start");
    beat(64'h5000, 2'd0, 1'b1, 1'b1, "R8 stop hit applies next beat");
    beat(64'h5004, 2'd0, 1'b1, 1'b0, "R8 blocked after stop");

    wr(8'h00, 64'd0);
    wr(8'h15, 64'h4000);
    wr(8'h00, 64'd1);
    beat(64'h4000, 2'd0, 1'b1, 1'b0, "R9 joint hit from stopped");
    beat(64'h10,   2'd0, 1'b1, 1'b0, "R9 stays stopped after joint hit");
    wr(8'h00, 64'd0);
    wr(8'h01, 64'h201);
    wr(8'h00, 64'd1);
    beat(64'h4000, 2'd0, 1'b1, 1'b1, "R9 joint hit beat uses old state");
    beat(64'h10,   2'd0, 1'b1, 1'b0, "R9 stop wins over start");
    chk("R9 state cleared", 64'(ss_started), 64'd0);

    wr(8'h00, 64'd0);
    repeat (3) @(negedge clk);
    chk("R10 state held after stop", 64'(ss_started), 64'd0);
    wr(8'h01, 64'h201);
    chk("R10 preset started", 64'(ss_started), 64'd1);
    wr(8'h15, 64'h5000);
    wr(8'h00, 64'd1);
    beat(64'h10, 2'd0, 1'b1, 1'b1, "R10 resumes from preset state");

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule